// File: doc/BRIEF.md
# Clock Failure Trap Generator

This block watches a handful of clock-health inputs and raises a hard trap request whenever the system clock or its PLL stops behaving. It recognises three failure causes and merges them into one sticky trap flag.

- **Lost clock source:** the clock monitor is enabled and reports that the clock source has gone.
- **Lost lock in normal operation:** the PLL is the selected clock, power-on reset is over, and lock drops.
- **No lock at power-on:** the clock monitor is enabled and the PLL has not locked before a lock-timeout counter expires while power-on reset is still active.

The trap request carries a fixed priority level of 14. It stays high for as long as the trap flag is set.

A second sticky bit, the clock-fail bit, is set together with the trap flag and is cleared on its own. Software reads both bits through a small status port and clears them with a write-one-to-clear strobe. A handler therefore clears the trap flag before it returns, so that it is not re-entered. The oscillator itself and the clock switchover logic lie outside the block; loss of clock reaches it as a plain input.

All pins are plain control and status pins. No part of the interface carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `clkfail_trap`

## Requirements
- R1: After reset, the trap request is 0 and both status bits are 0. Status bit 0 is the trap flag and bit 1 is the clock-fail bit.
- R2: When `mon_en_i` and `clk_lost_i` are both high at a clock edge, both status bits and the trap request are 1 after that edge. With `mon_en_i` low, `clk_lost_i` has no effect.
- R3: When `pll_sel_i` is 1, `pll_locked_i` is 0 and `por_active_i` is 0 at an edge, both status bits are set after that edge. With `pll_sel_i` low, loss of lock has no effect.
- R4: The power-on lock timeout works as follows:
  - It starts when `mon_en_i`, `por_active_i` and `pll_sel_i` are high and `pll_locked_i` is low.
  - If that condition holds for LOCK_TIMEOUT+1 consecutive edges, both status bits are set at the last of those edges, and not before.
  - The count restarts from zero whenever `por_active_i`, `pll_sel_i` or the missing lock does not hold.
  - With `mon_en_i` low the timeout never raises the trap.
- R5: `trap_level_o` always reads 14. `trap_req_o` rises only in the cycle after a failure cause was present.
- R6: Once set, a status bit stays set after every cause has gone, until software clears it.
- R7: A write (`csr_wr_i`=1) clears each status bit whose `csr_wdata_i` bit is 1 at the next edge. Bits written 0 keep their value.
- R8: If a failure cause is present in the same cycle as a clear, both bits are set after that edge; the set wins.
- R9: Loss of lock while `por_active_i` is high does not raise the normal-operation trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en_i | input | 1 | Clock monitor enable |
| clk_lost_i | input | 1 | Clock monitor reports loss of the clock source |
| pll_sel_i | input | 1 | PLL is the selected clock source |
| pll_locked_i | input | 1 | PLL lock indication |
| por_active_i | input | 1 | Power-on reset in progress |
| csr_wr_i | input | 1 | Status write strobe (write-one-to-clear) |
| csr_wdata_i | input | 2 | Clear mask: bit 0 trap flag, bit 1 clock-fail bit |
| csr_rdata_o | output | 2 | Status read: bit 0 trap flag, bit 1 clock-fail bit |
| trap_req_o | output | 1 | Hard trap request |
| trap_level_o | output | 4 | Fixed trap priority (14) |

## Verification
Setting a flag from a failure cause and clearing it from software can fall in the same cycle. The bench provokes this in two ways:
- a write-one-to-clear is issued while the monitor reports a lost clock;
- a clear is issued while the power-on lock timeout is still expired.

In both cases the flags must read 1 after the edge. A clear issued once every cause has gone must then take effect. The bench also holds the lock-timeout condition for one edge short of the limit and then for exactly the limit, which pins down the edge on which the power-on cause fires.

// File: rtl/clkfail_pkg.sv
package clkfail_pkg;
  localparam int unsigned LEVEL_W   = 4;
  localparam logic [LEVEL_W-1:0] HARD_TRAP_LEVEL = 4'd14;
  localparam int unsigned STAT_W    = 2;
  localparam int unsigned STAT_TRAP = 0;
  localparam int unsigned STAT_CF   = 1;

  typedef struct packed {
    logic src_lost;
    logic run_unlock;
    logic por_nolock;
  } fail_cause_t;
endpackage

// File: rtl/clkfail_lock_timer.sv
module clkfail_lock_timer #(
  parameter int unsigned LOCK_TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_active_i,
  input  logic pll_sel_i,
  input  logic pll_locked_i,
  output logic timeout_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_TIMEOUT);

  logic             waiting;
  logic [CNT_W-1:0] cnt_q;

  assign waiting = por_active_i && pll_sel_i && !pll_locked_i;

  // Saturating count of consecutive edges spent waiting for lock in reset
  always_ff @(posedge clk) begin
    if (!rst_n || !waiting) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = waiting && (cnt_q == CNT_MAX);
endmodule

// File: rtl/clkfail_cause.sv
module clkfail_cause
  import clkfail_pkg::*;
(
  input  logic        mon_en_i,
  input  logic        clk_lost_i,
  input  logic        pll_sel_i,
  input  logic        pll_locked_i,
  input  logic        por_active_i,
  input  logic        por_timeout_i,
  output fail_cause_t cause_o,
  output logic        any_fail_o
);
  always_comb begin
    cause_o.src_lost   = mon_en_i && clk_lost_i;
    cause_o.run_unlock = pll_sel_i && !pll_locked_i && !por_active_i;
    cause_o.por_nolock = mon_en_i && por_timeout_i;
  end

  assign any_fail_o = |cause_o;
endmodule

// File: rtl/clkfail_status.sv
module clkfail_status #(
  parameter int unsigned NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flags_o
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic flag_q;
    // A set in the same cycle outranks the software clear
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (set_i) begin
        flag_q <= 1'b1;
      end else if (clr_i[i]) begin
        flag_q <= 1'b0;
      end
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/clkfail_trap.sv
module clkfail_trap
  import clkfail_pkg::*;
#(
  parameter int unsigned LOCK_TIMEOUT = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mon_en_i,
  input  logic               clk_lost_i,
  input  logic               pll_sel_i,
  input  logic               pll_locked_i,
  input  logic               por_active_i,
  input  logic               csr_wr_i,
  input  logic [STAT_W-1:0]  csr_wdata_i,
  output logic [STAT_W-1:0]  csr_rdata_o,
  output logic               trap_req_o,
  output logic [LEVEL_W-1:0] trap_level_o
);
  logic        por_timeout;
  fail_cause_t cause;
  logic        any_fail;
  logic [STAT_W-1:0] clr_mask;
  logic [STAT_W-1:0] flags;

  clkfail_lock_timer #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_active_i (por_active_i),
    .pll_sel_i    (pll_sel_i),
    .pll_locked_i (pll_locked_i),
    .timeout_o    (por_timeout)
  );

  clkfail_cause u_cause (
    .mon_en_i      (mon_en_i),
    .clk_lost_i    (clk_lost_i),
    .pll_sel_i     (pll_sel_i),
    .pll_locked_i  (pll_locked_i),
    .por_active_i  (por_active_i),
    .por_timeout_i (por_timeout),
    .cause_o       (cause),
    .any_fail_o    (any_fail)
  );

  assign clr_mask = {STAT_W{csr_wr_i}} & csr_wdata_i;

  clkfail_status #(.NFLAG(STAT_W)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (any_fail),
    .clr_i   (clr_mask),
    .flags_o (flags)
  );

  assign csr_rdata_o  = flags;
  assign trap_req_o   = flags[STAT_TRAP];
  assign trap_level_o = HARD_TRAP_LEVEL;
endmodule

// File: rtl/clkfail_trap_chk.sv
module clkfail_trap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mon_en_i,
  input logic       clk_lost_i,
  input logic       pll_sel_i,
  input logic       pll_locked_i,
  input logic       por_active_i,
  input logic       csr_wr_i,
  input logic [1:0] csr_wdata_i,
  input logic [1:0] csr_rdata_o,
  input logic       trap_req_o,
  input logic       por_timeout
);
  logic any_cause;
  assign any_cause = (mon_en_i && clk_lost_i)
                   || (pll_sel_i && !pll_locked_i && !por_active_i)
                   || (mon_en_i && por_timeout);

  AST_SET_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en_i && clk_lost_i) |=> (csr_rdata_o == 2'b11)); // R2

  AST_SET_ON_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_sel_i && !pll_locked_i && !por_active_i) |=> (csr_rdata_o == 2'b11)); // R3

  AST_RISE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req_o) |-> $past(any_cause)); // R5

  AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata_o[0] && !(csr_wr_i && csr_wdata_i[0])) |=> csr_rdata_o[0]); // R6

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_i && csr_wdata_i[0] && !any_cause) |=> !csr_rdata_o[0]); // R7

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cause && csr_wr_i) |=> (csr_rdata_o == 2'b11)); // R8
endmodule

bind clkfail_trap clkfail_trap_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mon_en_i     (mon_en_i),
  .clk_lost_i   (clk_lost_i),
  .pll_sel_i    (pll_sel_i),
  .pll_locked_i (pll_locked_i),
  .por_active_i (por_active_i),
  .csr_wr_i     (csr_wr_i),
  .csr_wdata_i  (csr_wdata_i),
  .csr_rdata_o  (csr_rdata_o),
  .trap_req_o   (trap_req_o),
  .por_timeout  (por_timeout)
);

// File: tb/clkfail_trap_test.sv
`timescale 1ns/1ps
module clkfail_trap_test;
  localparam int unsigned TMO = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mon_en, clk_lost, pll_sel, pll_locked, por_active, csr_wr;
  logic [1:0] csr_wdata;
  logic [1:0] csr_rdata;
  logic       trap_req;
  logic [3:0] trap_level;

  typedef struct {
    logic       req;
    logic [1:0] rd;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   errors  = 0;
  bit   done    = 1'b0;

  always #2.5 clk = ~clk;

  clkfail_trap #(.LOCK_TIMEOUT(TMO)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mon_en_i     (mon_en),
    .clk_lost_i   (clk_lost),
    .pll_sel_i    (pll_sel),
    .pll_locked_i (pll_locked),
    .por_active_i (por_active),
    .csr_wr_i     (csr_wr),
    .csr_wdata_i  (csr_wdata),
    .csr_rdata_o  (csr_rdata),
    .trap_req_o   (trap_req),
    .trap_level_o (trap_level)
  );

  // Driver: inputs change at the falling edge, the expected result after the next rising edge
  task automatic step(input logic m, input logic l, input logic s, input logic k,
                      input logic p, input logic w, input logic [1:0] wd,
                      input logic ereq, input logic [1:0] erd, input string tag);
    @(negedge clk);
    mon_en = m; clk_lost = l; pll_sel = s; pll_locked = k;
    por_active = p; csr_wr = w; csr_wdata = wd;
    q.push_back('{ereq, erd, tag});
  endtask

  // Monitor: compare one millisecond... one nanosecond after each rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        vectors++;
        if (trap_req !== e.req || csr_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s: req=%b rdata=%b expected req=%b rdata=%b",
                   e.tag, trap_req, csr_rdata, e.req, e.rd);
        end
        if (trap_level !== 4'd14) begin
          errors++;
          $display("FAIL R5: level=%0d expected 14", trap_level);
        end
      end
    end
  end

  initial begin
    mon_en = 0; clk_lost = 0; pll_sel = 0; pll_locked = 1;
    por_active = 0; csr_wr = 0; csr_wdata = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step(0,0,0,1,0,0,2'b00, 0,2'b00, "R1 reset state");
    step(0,1,0,1,0,0,2'b00, 0,2'b00, "R2 loss ignored with monitor off");
    step(1,1,0,1,0,0,2'b00, 1,2'b11, "R2 loss with monitor on");
    step(0,0,0,1,0,0,2'b00, 1,2'b11, "R6 sticky after cause gone");
    step(0,0,0,1,0,0,2'b00, 1,2'b11, "R6 sticky second cycle");
    step(0,0,0,1,0,1,2'b01, 0,2'b10, "R7 clear trap flag only");
    step(0,0,0,1,0,1,2'b10, 0,2'b00, "R7 clear clock-fail bit");
    step(0,0,0,0,0,0,2'b00, 0,2'b00, "R3 unlock ignored when PLL not selected");
    for (int i = 0; i < 3; i++)
      step(0,0,1,0,1,0,2'b00, 0,2'b00, "R9 unlock during power-on reset");
    step(0,0,1,0,0,0,2'b00, 1,2'b11, "R3 unlock in normal operation");
    step(0,0,1,1,0,1,2'b11, 0,2'b00, "R7 clear both bits");
    step(1,1,0,1,0,1,2'b11, 1,2'b11, "R8 set wins over clear");
    step(0,0,0,1,0,1,2'b11, 0,2'b00, "R7 clear after cause gone");
    for (int i = 0; i < TMO + 4; i++)
      step(0,0,1,0,1,0,2'b00, 0,2'b00, "R4 timeout ignored with monitor off");
    step(0,0,0,1,0,0,2'b00, 0,2'b00, "R4 idle between runs");
    for (int i = 0; i < TMO; i++)
      step(1,0,1,0,1,0,2'b00, 0,2'b00, "R4 before timeout limit");
    step(1,0,1,0,1,0,2'b00, 1,2'b11, "R4 timeout reached");
    step(1,0,1,0,1,1,2'b11, 1,2'b11, "R8 clear during expired timeout");
    step(1,0,1,1,0,1,2'b11, 0,2'b00, "R7 clear once locked");
    for (int i = 0; i < TMO; i++)
      step(1,0,1,0,1,0,2'b00, 0,2'b00, "R4 partial wait");
    step(1,0,1,1,1,0,2'b00, 0,2'b00, "R4 lock restarts count");
    for (int i = 0; i < TMO; i++)
      step(1,0,1,0,1,0,2'b00, 0,2'b00, "R4 count restarted from zero");
    step(1,0,1,0,1,0,2'b00, 1,2'b11, "R4 timeout after restart");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule